// File: doc/BRIEF.md
# Serial Port Interrupt Source, Mask and Pending Unit

This block gathers the four interrupt causes of one serial port channel into a source word. It masks that word to form a pending word and drives a single level-sensitive interrupt line. Events from the receive path, the error detector, the transmit path and the modem-status logic arrive as single-cycle set pulses. Software clears bits through two write ports. One clears the pending view, and with it the matching source bits. The other clears source bits only. A third write port loads the mask word.

The block also raises the transmit request by itself. When FIFO mode is on, the transmit source bit is set on every cycle in which the current transmit FIFO fill count is at or below a threshold. The threshold is a 3-bit trigger field times a scale factor. The scale factor is fixed by the channel-number parameter, because the channels have FIFOs of different depths.

Top module: `uart_irq_unit`

## Requirements
- R1: After reset, both the source word and the mask word are zero. With FIFO mode off, the pending word is zero and the interrupt line is low.
- R2: Source bit positions are: receive = bit 0, error = bit 1, transmit = bit 2, modem = bit 3. A set pulse on an event input makes its bit 1 at the next rising clock edge. The bit then stays 1 until it is cleared.
- R3: The pending word always equals the source word AND the inverted mask word. The interrupt line is high exactly when the pending word is nonzero.
- R4: A pending-port write clears, at the next edge, every source bit (and therefore every pending bit) where the written data has a 1. Source bits where the data has a 0 are unchanged.
- R5: A source-port write clears only the source bits where the written data has a 1. The mask word is not changed.
- R6: A mask-port write loads the written data into the mask word at the next edge. The pending word and the interrupt line reflect the new mask in that same cycle.
- R7: The transmit threshold is the trigger field (config bits 2:0) times 32 for channel 0, times 8 for channels 1 and 4, and times 2 for channels 2 and 3. For any other channel the threshold is 0.
- R8: With FIFO mode on, the transmit source bit is set at each edge at which the transmit count is less than or equal to the threshold. With FIFO mode off, no automatic transmit request is made.
- R9: A set of a bit, whether from a pulse or the automatic transmit request, wins over a clear of the same bit in the same cycle, so the bit is 1 afterwards.
- R10: When both clear ports are written in the same cycle, the cleared bits are the union of the two data words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_rx | input | 1 | Receive event set pulse |
| ev_err | input | 1 | Error event set pulse |
| ev_tx | input | 1 | Transmit event set pulse |
| ev_modem | input | 1 | Modem-status event set pulse |
| fifo_en | input | 1 | FIFO mode enable |
| tx_trig | input | 3 | Transmit trigger-level field |
| tx_count | input | 8 | Current transmit FIFO fill count |
| pend_wr | input | 1 | Pending-port write strobe |
| pend_wdata | input | 4 | Pending-port write data (1 bits clear) |
| src_wr | input | 1 | Source-port write strobe |
| src_wdata | input | 4 | Source-port write data (1 bits clear) |
| mask_wr | input | 1 | Mask-port write strobe |
| mask_wdata | input | 4 | Mask word write data |
| src_q | output | 4 | Source word |
| mask_q | output | 4 | Mask word |
| pend_o | output | 4 | Pending word |
| irq_o | output | 1 | Interrupt line |

## Verification
A corrupted source or mask bit shows on `src_q` or `mask_q` in the cycle after the faulty edge. When the bit is unmasked, it also shows on `pend_o` and `irq_o` in that same cycle. The bench uses three channel values (0, 4 and 5) and sweeps the transmit count across each threshold. A wrong scale factor or an off-by-one compare therefore shows up as a missing or extra transmit bit one edge after the count crosses. Because a set wins over a clear, a lost event shows up as a zero on the affected bit right after a clear that coincided with the event.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int SRC_N   = 4;
  localparam int IDX_RX  = 0;
  localparam int IDX_ERR = 1;
  localparam int IDX_TX  = 2;
  localparam int IDX_MDM = 3;

  // scale applied to the transmit trigger field, selected by channel number
  function automatic int unsigned trig_scale(input int unsigned channel);
    case (channel)
      0:       return 32;
      1, 4:    return 8;
      2, 3:    return 2;
      default: return 0;
    endcase
  endfunction

  function automatic int unsigned tx_threshold(input int unsigned channel,
                                               input int unsigned field);
    return field * trig_scale(channel);
  endfunction
endpackage

// File: rtl/uart_irq_txreq.sv
module uart_irq_txreq
  import uart_irq_pkg::*;
#(
  parameter int unsigned CHANNEL = 0,
  parameter int CNT_W  = 8,
  parameter int TRIG_W = 3
) (
  input  logic              fifo_en,
  input  logic [TRIG_W-1:0] trig,
  input  logic [CNT_W-1:0]  count,
  output logic              tx_req
);
  int unsigned thr;
  int unsigned cnt_ext;

  always_comb begin
    thr     = tx_threshold(CHANNEL, 32'(trig));
    cnt_ext = 32'(count);
    tx_req  = fifo_en && (cnt_ext <= thr);
  end
endmodule

// File: rtl/uart_irq_srcreg.sv
module uart_irq_srcreg #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] src_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= '0;
    else        src_q <= (src_q & ~clr_i) | set_i;
  end

  // R9: a set bit is present after the edge regardless of clears
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((src_q & $past(set_i)) == $past(set_i)));

  // R4: cleared bits without a set are zero afterwards
  a_r4_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i != '0 && set_i == '0) |=> ((src_q & $past(clr_i)) == '0));

  // R2: no set and no clear keeps the word
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i == '0 && set_i == '0) |=> $stable(src_q));
endmodule

// File: rtl/uart_irq_maskreg.sv
module uart_irq_maskreg #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] mask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  mask_q <= '0;
    else if (wr) mask_q <= wdata;
  end

  a_r6_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (mask_q == $past(wdata)));

  a_r5_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(mask_q));
endmodule

// File: rtl/uart_irq_unit.sv
module uart_irq_unit
  import uart_irq_pkg::*;
#(
  parameter int unsigned CHANNEL = 0,
  parameter int CNT_W  = 8,
  parameter int TRIG_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_rx,
  input  logic              ev_err,
  input  logic              ev_tx,
  input  logic              ev_modem,
  input  logic              fifo_en,
  input  logic [TRIG_W-1:0] tx_trig,
  input  logic [CNT_W-1:0]  tx_count,
  input  logic              pend_wr,
  input  logic [SRC_N-1:0]  pend_wdata,
  input  logic              src_wr,
  input  logic [SRC_N-1:0]  src_wdata,
  input  logic              mask_wr,
  input  logic [SRC_N-1:0]  mask_wdata,
  output logic [SRC_N-1:0]  src_q,
  output logic [SRC_N-1:0]  mask_q,
  output logic [SRC_N-1:0]  pend_o,
  output logic              irq_o
);
  logic             tx_auto;
  logic [SRC_N-1:0] set_vec;
  logic [SRC_N-1:0] clr_vec;

  uart_irq_txreq #(.CHANNEL(CHANNEL), .CNT_W(CNT_W), .TRIG_W(TRIG_W)) u_txreq (
    .fifo_en (fifo_en),
    .trig    (tx_trig),
    .count   (tx_count),
    .tx_req  (tx_auto)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[IDX_RX]  = ev_rx;
    set_vec[IDX_ERR] = ev_err;
    set_vec[IDX_TX]  = ev_tx | tx_auto;
    set_vec[IDX_MDM] = ev_modem;
    clr_vec = (pend_wr ? pend_wdata : '0) | (src_wr ? src_wdata : '0);
  end

  uart_irq_srcreg #(.N(SRC_N)) u_src (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (set_vec),
    .clr_i (clr_vec),
    .src_q (src_q)
  );

  uart_irq_maskreg #(.N(SRC_N)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (mask_wr),
    .wdata  (mask_wdata),
    .mask_q (mask_q)
  );

  assign pend_o = src_q & ~mask_q;
  assign irq_o  = |pend_o;

  // R8: automatic transmit request reaches the source word one edge later
  a_r8_tx_auto: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && (32'(tx_count) <= tx_threshold(CHANNEL, 32'(tx_trig)))) |=> src_q[IDX_TX]);

  // R8: nothing automatic while FIFO mode is off
  a_r8_no_auto_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && !ev_tx && src_wr && src_wdata[IDX_TX]) |=> !src_q[IDX_TX]);

  // R3: a masked source bit never reaches the line
  a_r3_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_q & ~mask_q) == '0) |-> !irq_o);
endmodule

// File: tb/uart_irq_unit_test.sv
module uart_irq_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_rx = 0, ev_err = 0, ev_tx = 0, ev_modem = 0;
  logic fifo_en = 0;
  logic [2:0] tx_trig = 0;
  logic [7:0] tx_count = 0;
  logic pend_wr = 0, src_wr = 0, mask_wr = 0;
  logic [3:0] pend_wdata = 0, src_wdata = 0, mask_wdata = 0;

  logic [3:0] src_a [3];
  logic [3:0] mask_a[3];
  logic [3:0] pend_a[3];
  logic       irq_a [3];

  int checks = 0, fails = 0, cycles = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  uart_irq_unit #(.CHANNEL(0)) uut (
    .clk, .rst_n, .ev_rx, .ev_err, .ev_tx, .ev_modem, .fifo_en, .tx_trig, .tx_count,
    .pend_wr, .pend_wdata, .src_wr, .src_wdata, .mask_wr, .mask_wdata,
    .src_q(src_a[0]), .mask_q(mask_a[0]), .pend_o(pend_a[0]), .irq_o(irq_a[0]));
  uart_irq_unit #(.CHANNEL(4)) uut_c4 (
    .clk, .rst_n, .ev_rx, .ev_err, .ev_tx, .ev_modem, .fifo_en, .tx_trig, .tx_count,
    .pend_wr, .pend_wdata, .src_wr, .src_wdata, .mask_wr, .mask_wdata,
    .src_q(src_a[1]), .mask_q(mask_a[1]), .pend_o(pend_a[1]), .irq_o(irq_a[1]));
  uart_irq_unit #(.CHANNEL(5)) uut_c5 (
    .clk, .rst_n, .ev_rx, .ev_err, .ev_tx, .ev_modem, .fifo_en, .tx_trig, .tx_count,
    .pend_wr, .pend_wdata, .src_wr, .src_wdata, .mask_wr, .mask_wdata,
    .src_q(src_a[2]), .mask_q(mask_a[2]), .pend_o(pend_a[2]), .irq_o(irq_a[2]));

  // reference model: channel 0 scales by 32, channel 4 by 8, channel 5 gives 0
  int   factor [3] = '{32, 8, 0};
  logic [3:0] m_src [3];
  logic [3:0] m_mask;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 3; k++) m_src[k] <= 4'h0;
      m_mask <= 4'h0;
    end else begin
      for (int k = 0; k < 3; k++) begin
        logic [3:0] setb, clrb;
        logic txa;
        txa  = fifo_en && (int'(tx_count) <= int'(tx_trig) * factor[k]);
        setb = {ev_modem, ev_tx | txa, ev_err, ev_rx};
        clrb = 4'h0;
        if (pend_wr) clrb = clrb | pend_wdata;
        if (src_wr)  clrb = clrb | src_wdata;
        m_src[k] <= (m_src[k] & ~clrb) | setb;
      end
      if (mask_wr) m_mask <= mask_wdata;
    end
  end

  task automatic check4(string what, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    for (int k = 0; k < 3; k++) begin
      logic [3:0] ep;
      ep = m_src[k] & ~m_mask;
      check4($sformatf("src[%0d]", k),  src_a[k],  m_src[k]);
      check4($sformatf("mask[%0d]", k), mask_a[k], m_mask);
      check4($sformatf("pend[%0d] (R3)", k), pend_a[k], ep);
      check4($sformatf("irq[%0d] (R3)", k),  {3'b0, irq_a[k]}, {3'b0, ep != 4'h0});
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_strobes();
    ev_rx = 0; ev_err = 0; ev_tx = 0; ev_modem = 0;
    pend_wr = 0; src_wr = 0; mask_wr = 0;
  endtask

  task automatic step();
    @(negedge clk);
    clear_strobes();
  endtask

  initial begin : watchdog
    wait (cycles > 20000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    idle(3);
    cur_req = "R1";
    check4("reset src", src_a[0], 4'h0);
    check4("reset mask", mask_a[0], 4'h0);
    rst_n = 1;
    idle(2);

    cur_req = "R2";
    ev_rx = 1;    step();
    ev_err = 1;   step();
    ev_tx = 1;    step();
    ev_modem = 1; step();
    check4("all sources set", src_a[0], 4'hF);

    cur_req = "R6";
    mask_wr = 1; mask_wdata = 4'b1010; step();
    check4("pend after mask", pend_a[0], 4'b0101);
    mask_wr = 1; mask_wdata = 4'hF; step();
    cur_req = "R3";
    check4("irq fully masked", {3'b0, irq_a[0]}, 4'h0);
    mask_wr = 1; mask_wdata = 4'h0; step();

    cur_req = "R4";
    pend_wr = 1; pend_wdata = 4'b0011; step();
    check4("pend clear", src_a[0], 4'b1100);

    cur_req = "R5";
    mask_wr = 1; mask_wdata = 4'b0110; step();
    src_wr = 1; src_wdata = 4'b0100; step();
    check4("src clear", src_a[0], 4'b1000);
    check4("mask unchanged", mask_a[0], 4'b0110);

    cur_req = "R9";
    ev_rx = 1; pend_wr = 1; pend_wdata = 4'b1001; step();
    check4("set beats clear", src_a[0], 4'b0001);

    cur_req = "R10";
    ev_err = 1; ev_modem = 1; step();
    pend_wr = 1; pend_wdata = 4'b0001; src_wr = 1; src_wdata = 4'b1000; step();
    check4("union clear", src_a[0], 4'b0010);
    src_wr = 1; src_wdata = 4'hF; mask_wr = 1; mask_wdata = 4'h0; step();

    cur_req = "R8";
    fifo_en = 0; tx_trig = 3'd7; tx_count = 0; idle(3);
    check4("no auto when off", src_a[0], 4'h0);

    cur_req = "R7";
    fifo_en = 1;
    for (int t = 0; t < 8; t += 7) begin
      tx_trig = 3'(t == 0 ? 1 : 7);
      for (int c = 0; c < 256; c++) begin
        tx_count = 8'(c);
        src_wr = 1; src_wdata = 4'b0100;
        step();
      end
    end
    tx_trig = 3'd0;
    tx_count = 8'd0; step();
    cur_req = "R8";
    check4("trig 0 count 0 on ch5", src_a[2], 4'b0100);
    tx_count = 8'd1; src_wr = 1; src_wdata = 4'hF; step();
    idle(1);
    check4("trig 0 count 1 ch0", src_a[0], 4'h0);

    cur_req = "R9";
    tx_count = 8'd0; src_wr = 1; src_wdata = 4'b0100; step();
    check4("auto tx beats clear", src_a[0], 4'b0100);

    idle(2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule